// File: doc/BRIEF.md
# Every-Nth Pulse Gate

The block watches a pulse train whose spacing is irregular and lets only one pulse in every N reach its output. A pulse that is let through keeps its width, measured in system clock cycles. The pulses it skips leave the output low. N comes from a 4-bit input that may change while the block runs.

The pulse input is sampled by the system clock through a multi-stage synchronizer. No logic is clocked by the pulse itself, and the design has no latches. A falling edge on the synchronized level advances a pulse count. At each falling edge a registered select flag records whether the next pulse is the one to pass. The output register is the synchronized level ANDed with that flag. The output therefore copies the input width exactly, delayed by a fixed number of cycles. A new N is taken only when a group of N pulses completes, so a change never disturbs the group in progress.

Top module: `every_nth_gate`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears its pulse count and forces `pulse_o` low. It also loads the group size from `n_i`. The first pulse passed after reset is the Nth pulse after reset.
- R2: Within each group of N consecutive input pulses, only the last one (the Nth) drives `pulse_o` high. For every other pulse, `pulse_o` stays low.
- R3: A passed pulse appears on `pulse_o` with the same number of high clock cycles as the input pulse. It is delayed by SYNC_STAGES+1 cycles, which is 3 cycles at the default setting.
- R4: `n_i` is an unsigned 4-bit group size. Values 1 through 15 are used as given, and the value 0 acts as 1.
- R5: With a group size of 1, every input pulse passes.
- R6: A new `n_i` value takes effect only when the current group completes, after the falling edge of its Nth pulse. Pulses of the group in progress are counted against the old size.
- R7: The result does not depend on the spacing of the pulses. Any high time and any low time of at least SYNC_STAGES+2 cycles give the same selection.
- R8: The count wraps with no gap. The pulse that follows a passed pulse is the first of the next group, so with a steady N the pulses numbered N, 2N, 3N and so on pass.
- R9: The pulse count and the select flag change only on a falling edge of the synchronized input, and the count always stays below the active group size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pulse_i | input | 1 | Irregular pulse input, asynchronous to `clk` |
| n_i | input | 4 | Group size N (0 acts as 1) |
| pulse_o | output | 1 | Gated pulse output, registered |

## Verification
A wrong count or select state shows at the port within one pulse. It appears as a pulse passed out of turn or a selected pulse that stays missing, and every later selection shifts with it. A fault in the output path shows as a width that differs from the input width in the same pulse window. The sweep runs every group size over more than two groups, with varied widths and gaps, to catch all of these. It also covers a size change in mid-group and a reset in mid-group, which expose an early size load or a count that survives reset.

// File: rtl/every_nth_gate_pkg.sv
package every_nth_gate_pkg;
  localparam int unsigned NSEL_W = 4;
  typedef logic [NSEL_W-1:0] nsel_t;

  function automatic nsel_t eff_size(input nsel_t raw);
    eff_size = (raw == '0) ? nsel_t'(1) : raw;
  endfunction
endpackage

// File: rtl/npg_sync.sv
module npg_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic level_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= async_i;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], async_i};
      end
    end
  endgenerate

  assign level_o = chain_q[STAGES-1];
endmodule

// File: rtl/npg_edge.sv
module npg_edge (
  input  logic clk,
  input  logic rst,
  input  logic level_i,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= level_i;
  end

  assign fall_o = prev_q & ~level_i;
endmodule

// File: rtl/npg_count.sv
module npg_count
  import every_nth_gate_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  fall_i,
  input  nsel_t n_i,
  output nsel_t cnt_o,
  output nsel_t size_o,
  output logic  sel_o
);
  nsel_t cnt_q, size_q, next_cnt, n_eff;
  logic  sel_q, at_last;

  always_comb begin
    n_eff    = eff_size(n_i);
    at_last  = (cnt_q == size_q - nsel_t'(1));
    next_cnt = cnt_q + nsel_t'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      size_q <= n_eff;
      sel_q  <= (n_eff == nsel_t'(1));
    end else if (fall_i) begin
      if (at_last) begin
        cnt_q  <= '0;
        size_q <= n_eff;
        sel_q  <= (n_eff == nsel_t'(1));
      end else begin
        cnt_q  <= next_cnt;
        sel_q  <= (next_cnt == size_q - nsel_t'(1));
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign size_o = size_q;
  assign sel_o  = sel_q;
endmodule

// File: rtl/npg_out.sv
module npg_out (
  input  logic clk,
  input  logic rst,
  input  logic level_i,
  input  logic sel_i,
  output logic pulse_o
);
  logic out_q;

  always_ff @(posedge clk) begin
    if (rst) out_q <= 1'b0;
    else     out_q <= level_i & sel_i;
  end

  assign pulse_o = out_q;
endmodule

// File: rtl/every_nth_gate.sv
module every_nth_gate
  import every_nth_gate_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pulse_i,
  input  logic [3:0] n_i,
  output logic       pulse_o
);
  logic  lvl_w, fall_w, sel_w;
  nsel_t cnt_w, size_w;

  npg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_i(pulse_i), .level_o(lvl_w));

  npg_edge u_edge (
    .clk(clk), .rst(rst), .level_i(lvl_w), .fall_o(fall_w));

  npg_count u_count (
    .clk(clk), .rst(rst), .fall_i(fall_w), .n_i(n_i),
    .cnt_o(cnt_w), .size_o(size_w), .sel_o(sel_w));

  npg_out u_out (
    .clk(clk), .rst(rst), .level_i(lvl_w), .sel_i(sel_w), .pulse_o(pulse_o));
endmodule

// File: rtl/every_nth_gate_chk.sv
module every_nth_gate_chk (
  input logic       clk,
  input logic       rst,
  input logic       fall,
  input logic       sel,
  input logic [3:0] cnt,
  input logic [3:0] size,
  input logic       pulse_o
);
  p_out_low_reset_r1: assert property (@(posedge clk) rst |=> !pulse_o)
    else $error("R1: output not low after reset");

  p_rise_needs_sel_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse_o) |-> $past(sel))
    else $error("R2: output rose without select");

  p_size_nonzero_r4: assert property (@(posedge clk) disable iff (rst)
    size != 4'd0)
    else $error("R4: active size is zero");

  p_size_only_at_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    !$stable(size) |-> (cnt == 4'd0))
    else $error("R6: size changed outside wrap");

  p_cnt_stable_r9: assert property (@(posedge clk) disable iff (rst)
    !fall |=> $stable(cnt))
    else $error("R9: count moved without falling edge");

  p_sel_stable_r9: assert property (@(posedge clk) disable iff (rst)
    !fall |=> $stable(sel))
    else $error("R9: select moved without falling edge");

  p_cnt_below_size_r9: assert property (@(posedge clk) disable iff (rst)
    cnt < size)
    else $error("R9: count not below size");
endmodule

bind every_nth_gate every_nth_gate_chk u_chk (
  .clk(clk), .rst(rst), .fall(fall_w), .sel(sel_w),
  .cnt(cnt_w), .size(size_w), .pulse_o(pulse_o));

// File: tb/every_nth_gate_tb.sv
module every_nth_gate_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pulse_i = 1'b0;
  logic [3:0] n_i = 4'd1;
  logic       pulse_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  int m_cnt = 0;
  int m_size = 1;

  every_nth_gate u_dut (
    .clk(clk), .rst(rst), .pulse_i(pulse_i), .n_i(n_i), .pulse_o(pulse_o));

  always #4 clk = ~clk;

  function automatic int eff(input logic [3:0] v);
    return (v == 4'd0) ? 1 : int'(v);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_cnt = 0;
    m_size = eff(n_i);
    check("R1 output low after reset", int'(pulse_o), 0);
  endtask

  task automatic pulse(input int hi, input int lo, input string req);
    int hits = 0;
    int exp_w;
    exp_w = (m_cnt == m_size - 1) ? hi : 0;
    pulse_i = 1'b1;
    for (int i = 0; i < hi + lo; i++) begin
      @(negedge clk);
      hits += int'(pulse_o);
      if (i == hi - 1) pulse_i = 1'b0;
    end
    check(req, hits, exp_w);
    m_cnt++;
    if (m_cnt == m_size) begin
      m_cnt = 0;
      m_size = eff(n_i);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    check("R1 idle output low", int'(pulse_o), 0);

    // R2 R3 R4 R5 R7 R8: sweep every size, more than two groups, varied widths and gaps
    for (int n = 0; n < 16; n++) begin
      n_i = 4'(n);
      do_reset();
      for (int k = 0; k < 2 * eff(4'(n)) + 2; k++) begin
        pulse(2 + (k * 3 + n) % 5, 4 + (k * 7 + n) % 9,
              (n <= 1) ? "R5 R4 every pulse passes" : "R2 R3 R7 R8 Nth pulse gate");
      end
    end

    // R6: size change mid-group takes effect after wrap
    n_i = 4'd5;
    do_reset();
    pulse(3, 5, "R6 old size pulse 1");
    pulse(4, 6, "R6 old size pulse 2");
    n_i = 4'd2;
    pulse(2, 4, "R6 old size pulse 3");
    pulse(5, 7, "R6 old size pulse 4");
    pulse(3, 5, "R6 old size pulse 5 passes");
    pulse(2, 4, "R6 new size pulse 1");
    pulse(6, 4, "R6 new size pulse 2 passes");
    n_i = 4'd0;
    pulse(2, 4, "R6 R4 new size pulse 3");
    pulse(3, 5, "R6 R4 new size pulse 4 passes");
    pulse(3, 5, "R6 R4 zero acts as one");

    // R1: reset mid-group restarts the count
    n_i = 4'd3;
    do_reset();
    pulse(3, 5, "R1 pre-reset pulse 1");
    pulse(3, 5, "R1 pre-reset pulse 2");
    do_reset();
    pulse(3, 5, "R1 post-reset pulse 1");
    pulse(4, 5, "R1 post-reset pulse 2");
    pulse(5, 5, "R1 post-reset pulse 3 passes");

    // R7: long irregular gaps
    n_i = 4'd2;
    do_reset();
    pulse(2, 40, "R7 long gap pulse 1");
    pulse(30, 4, "R7 long high pulse 2 passes");
    pulse(2, 200, "R7 very long gap pulse 3");
    pulse(2, 4, "R7 minimum spacing pulse 4 passes");

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule